// File: doc/BRIEF.md
# Reuse-Driven Fill Insertion Selector

This block decides what a last-level cache does with an incoming fill in a 16-way set: drop it (bypass) or place it at a chosen depth of the recency stack, where position 0 is the most-recently-used end and position 15 is the least-recently-used end. For each fill it takes three pieces of reuse evidence. The first is a hit flag from a zone access map. The second is the zone's access and reuse counts. The third is a class from a per-instruction filter. It combines them combinationally into a bypass flag and an insert position.

A 10-bit saturating selector runs set dueling between two kinds of dedicated sets. One kind always applies the reuse-driven policy. The other kind always inserts plainly, at position 0 with no bypass. Misses reported from these dedicated sets move the selector. Follower sets take whichever policy the selector's top bit favours.

A two-state machine tracks how biased the selector is. In state DUEL_FULL all dedicated sets keep their role. The transition BIAS_ENTER moves to DUEL_REDUCED when the selector comes within 64 of either limit. In DUEL_REDUCED half of the dedicated sets become followers. The transition BIAS_EXIT returns to DUEL_FULL once the selector leaves that band.

Top module: `ins_position_sel`

## Requirements
- R1: With the reuse policy in force, filter class code 0 (bypass class) sets `fill_bypass`. The class codes are 0 bypass, 1 useless, 2 normal, 3 useful and 4 reuse; codes 5 to 7 act as normal.
- R2: With the reuse policy in force, `fill_bypass` is set when the access count is strictly greater than 16 times the reuse count. An access count of 16 with a reuse count of 1 does not bypass. An access count of 1 with a reuse count of 0 does bypass.
- R3: The position starts at 15 and is halved by integer division when `map_reuse_hit` is 1.
- R4: The position is halved again when the reuse count is strictly greater than the access count, so that successive values are 15, 7, 3 and 1.
- R5: The filter class is applied last. Reuse forces 0, useful halves the current value, useless forces 15, and normal (and bypass) leave it unchanged.
- R6: With m = SET_W/2, a set is policy-dedicated when its low m index bits equal the next m bits. It is LRU-dedicated when the low m bits equal the bitwise inverse of the next m bits. All other sets are followers, and a follower uses the reuse policy exactly when the selector's top bit is 1.
- R7: A fill that uses plain insertion has `fill_bypass` = 0 and `fill_pos` = 0, whatever its map and filter inputs are. `fill_uses_map` reports which policy the fill used.
- R8: The selector resets to 512. A miss in an LRU-dedicated set increments it, saturating at 1023. A miss in a policy-dedicated set decrements it, saturating at 0. A miss in a follower set leaves it unchanged.
- R9: The block is in DUEL_REDUCED exactly when the selector is at least 960 or below 64. In that state, dedicated sets whose top index bit is 1 act as followers, and misses in those sets do not move the selector.
- R10: While `fill_valid` is 0, all three fill outputs are 0.
- R11: The fill outputs follow the fill inputs in the same cycle. A miss changes the selector and the state at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | A fill decision is requested |
| fill_set | input | SET_W | Set index of the fill |
| map_reuse_hit | input | 1 | Zone map reports the line was touched before |
| zone_acc_cnt | input | CNT_W | Zone access count |
| zone_reuse_cnt | input | CNT_W | Zone reuse count |
| filter_class | input | 3 | Per-instruction filter class code |
| miss_valid | input | 1 | A cache miss is reported |
| miss_set | input | SET_W | Set index of the reported miss |
| fill_bypass | output | 1 | Do not allocate the fill |
| fill_pos | output | POS_W | Recency-stack insert position |
| fill_uses_map | output | 1 | Fill decided by the reuse policy |

## Verification
On every cycle the assertions check the following: plain insertion never bypasses; the reuse and useless classes force their fixed depths; the bypass class sets the flag; every position lies on the halving chain; the idle outputs are quiet; the selector moves at most one step per cycle; and the reduced state occurs only inside the bias band. The order of the halving steps, the 16-to-1 ratio boundary, the set-role mapping, saturation at both ends, and the moment at which dedicated sets are demoted and restored can only be shown by the bench's directed scenarios. These scenarios walk the selector through chosen miss counts and then probe particular sets.

// File: rtl/ins_sel_pkg.sv
package ins_sel_pkg;

    typedef enum logic [2:0] {
        FC_BYPASS  = 3'd0,
        FC_USELESS = 3'd1,
        FC_NORMAL  = 3'd2,
        FC_USEFUL  = 3'd3,
        FC_REUSE   = 3'd4
    } filt_class_e;

    typedef enum logic [1:0] {
        ROLE_FOLLOW = 2'd0,
        ROLE_MAP    = 2'd1,
        ROLE_LRU    = 2'd2
    } set_role_e;

    typedef enum logic {
        DUEL_FULL    = 1'b0,
        DUEL_REDUCED = 1'b1
    } duel_state_e;

endpackage

// File: rtl/ins_set_role.sv
module ins_set_role
    import ins_sel_pkg::*;
#(
    parameter int SET_W = 10
) (
    input  logic [SET_W-1:0] set_idx,
    input  logic             reduced,
    output set_role_e        role
);
    localparam int HALF = SET_W / 2;

    logic [HALF-1:0] lo_bits;
    logic [HALF-1:0] hi_bits;
    logic            demote_bit;

    assign lo_bits    = set_idx[HALF-1:0];
    assign hi_bits    = set_idx[2*HALF-1:HALF];
    assign demote_bit = set_idx[SET_W-1];

    always_comb begin
        if (lo_bits == hi_bits) begin
            role = ROLE_MAP;
        end else if (lo_bits == ~hi_bits) begin
            role = ROLE_LRU;
        end else begin
            role = ROLE_FOLLOW;
        end
        if (reduced && demote_bit) begin
            role = ROLE_FOLLOW;
        end
    end
endmodule

// File: rtl/ins_psel_fsm.sv
module ins_psel_fsm
    import ins_sel_pkg::*;
#(
    parameter int PSEL_W = 10,
    parameter int MARGIN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_up,
    input  logic              step_down,
    output logic [PSEL_W-1:0] psel,
    output duel_state_e       state
);
    localparam logic [PSEL_W-1:0] PS_MAX = {PSEL_W{1'b1}};
    localparam logic [PSEL_W-1:0] PS_MID = PSEL_W'(1) << (PSEL_W - 1);
    localparam logic [PSEL_W-1:0] PS_HI  = PS_MAX - PSEL_W'(MARGIN) + PSEL_W'(1);
    localparam logic [PSEL_W-1:0] PS_LO  = PSEL_W'(MARGIN);

    logic [PSEL_W-1:0] psel_nxt;
    duel_state_e       state_nxt;
    logic              biased_nxt;

    always_comb begin
        psel_nxt = psel;
        if (step_up && (psel != PS_MAX)) begin
            psel_nxt = psel + PSEL_W'(1);
        end else if (step_down && (psel != '0)) begin
            psel_nxt = psel - PSEL_W'(1);
        end
    end

    assign biased_nxt = (psel_nxt >= PS_HI) || (psel_nxt < PS_LO);

    always_comb begin
        state_nxt = state;
        unique case (state)
            DUEL_FULL: begin
                if (biased_nxt) begin
                    state_nxt = DUEL_REDUCED;   // BIAS_ENTER
                end
            end
            DUEL_REDUCED: begin
                if (!biased_nxt) begin
                    state_nxt = DUEL_FULL;      // BIAS_EXIT
                end
            end
            default: state_nxt = DUEL_FULL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psel  <= PS_MID;
            state <= DUEL_FULL;
        end else begin
            psel  <= psel_nxt;
            state <= state_nxt;
        end
    end
endmodule

// File: rtl/ins_pos_calc.sv
module ins_pos_calc
    import ins_sel_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int POS_W    = 4,
    parameter int RATIO_SH = 4
) (
    input  logic             reuse_hit,
    input  logic [CNT_W-1:0] acc_cnt,
    input  logic [CNT_W-1:0] reuse_cnt,
    input  logic [2:0]       fclass,
    output logic             bypass,
    output logic [POS_W-1:0] pos
);
    localparam int WIDE_W = CNT_W + RATIO_SH;

    logic [WIDE_W-1:0] acc_wide;
    logic [WIDE_W-1:0] reuse_scaled;
    filt_class_e       cls;
    logic [POS_W-1:0]  depth;

    assign acc_wide     = WIDE_W'(acc_cnt);
    assign reuse_scaled = WIDE_W'(reuse_cnt) << RATIO_SH;

    always_comb begin
        unique case (fclass)
            3'd0:    cls = FC_BYPASS;
            3'd1:    cls = FC_USELESS;
            3'd3:    cls = FC_USEFUL;
            3'd4:    cls = FC_REUSE;
            default: cls = FC_NORMAL;
        endcase
    end

    always_comb begin
        depth = {POS_W{1'b1}};
        if (reuse_hit) begin
            depth = depth >> 1;
        end
        if (reuse_cnt > acc_cnt) begin
            depth = depth >> 1;
        end
        unique case (cls)
            FC_REUSE:   depth = '0;
            FC_USEFUL:  depth = depth >> 1;
            FC_USELESS: depth = {POS_W{1'b1}};
            default:    depth = depth;
        endcase
    end

    assign bypass = (cls == FC_BYPASS) || (acc_wide > reuse_scaled);
    assign pos    = depth;
endmodule

// File: rtl/ins_position_sel.sv
module ins_position_sel
    import ins_sel_pkg::*;
#(
    parameter int SET_W  = 10,
    parameter int CNT_W  = 8,
    parameter int POS_W  = 4,
    parameter int PSEL_W = 10,
    parameter int MARGIN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_valid,
    input  logic [SET_W-1:0] fill_set,
    input  logic             map_reuse_hit,
    input  logic [CNT_W-1:0] zone_acc_cnt,
    input  logic [CNT_W-1:0] zone_reuse_cnt,
    input  logic [2:0]       filter_class,
    input  logic             miss_valid,
    input  logic [SET_W-1:0] miss_set,
    output logic             fill_bypass,
    output logic [POS_W-1:0] fill_pos,
    output logic             fill_uses_map
);
    logic [PSEL_W-1:0] psel_q;
    duel_state_e       duel_state;
    logic              reduced;
    set_role_e         fill_role;
    set_role_e         miss_role;
    logic              calc_bypass;
    logic [POS_W-1:0]  calc_pos;
    logic              map_sel;

    assign reduced = (duel_state == DUEL_REDUCED);

    ins_set_role #(.SET_W(SET_W)) u_fill_role (
        .set_idx (fill_set),
        .reduced (reduced),
        .role    (fill_role)
    );

    ins_set_role #(.SET_W(SET_W)) u_miss_role (
        .set_idx (miss_set),
        .reduced (reduced),
        .role    (miss_role)
    );

    ins_psel_fsm #(.PSEL_W(PSEL_W), .MARGIN(MARGIN)) u_psel (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_up   (miss_valid && (miss_role == ROLE_LRU)),
        .step_down (miss_valid && (miss_role == ROLE_MAP)),
        .psel      (psel_q),
        .state     (duel_state)
    );

    ins_pos_calc #(.CNT_W(CNT_W), .POS_W(POS_W)) u_calc (
        .reuse_hit (map_reuse_hit),
        .acc_cnt   (zone_acc_cnt),
        .reuse_cnt (zone_reuse_cnt),
        .fclass    (filter_class),
        .bypass    (calc_bypass),
        .pos       (calc_pos)
    );

    always_comb begin
        unique case (fill_role)
            ROLE_MAP:    map_sel = 1'b1;
            ROLE_LRU:    map_sel = 1'b0;
            default:     map_sel = psel_q[PSEL_W-1];
        endcase
    end

    always_comb begin
        fill_bypass   = 1'b0;
        fill_pos      = '0;
        fill_uses_map = 1'b0;
        if (fill_valid) begin
            fill_uses_map = map_sel;
            if (map_sel) begin
                fill_bypass = calc_bypass;
                fill_pos    = calc_pos;
            end
        end
    end
endmodule

// File: rtl/ins_position_sel_chk.sv
module ins_position_sel_chk #(
    parameter int POS_W  = 4,
    parameter int PSEL_W = 10,
    parameter int MARGIN = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fill_valid,
    input logic [2:0]        filter_class,
    input logic              fill_bypass,
    input logic [POS_W-1:0]  fill_pos,
    input logic              fill_uses_map,
    input logic [PSEL_W-1:0] psel,
    input logic              reduced
);
    localparam logic [PSEL_W-1:0] HI_EDGE = {PSEL_W{1'b1}} - PSEL_W'(MARGIN) + PSEL_W'(1);
    localparam logic [PSEL_W-1:0] LO_EDGE = PSEL_W'(MARGIN);

    logic [POS_W:0] pos_plus;
    assign pos_plus = {1'b0, fill_pos} + (POS_W+1)'(1);

    AST_LRU_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_uses_map) |-> (!fill_bypass && fill_pos == '0)); // R7

    AST_CLASS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_uses_map && filter_class == 3'd0) |-> fill_bypass); // R1

    AST_REUSE_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_uses_map && filter_class == 3'd4) |-> (fill_pos == '0)); // R5

    AST_USELESS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_uses_map && filter_class == 3'd1) |-> (fill_pos == {POS_W{1'b1}})); // R5

    AST_POS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_pos == '0) || $onehot(pos_plus)); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid |-> (!fill_bypass && fill_pos == '0 && !fill_uses_map)); // R10

    AST_PSEL_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((psel == $past(psel)) || (psel == $past(psel) + PSEL_W'(1))
                  || (psel == $past(psel) - PSEL_W'(1)))); // R8

    AST_REDUCED_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        reduced |-> ((psel >= HI_EDGE) || (psel < LO_EDGE))); // R9

    AST_FULL_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        !reduced |-> ((psel < HI_EDGE) && (psel >= LO_EDGE))); // R9
endmodule

bind ins_position_sel ins_position_sel_chk #(
    .POS_W  (POS_W),
    .PSEL_W (PSEL_W),
    .MARGIN (MARGIN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fill_valid    (fill_valid),
    .filter_class  (filter_class),
    .fill_bypass   (fill_bypass),
    .fill_pos      (fill_pos),
    .fill_uses_map (fill_uses_map),
    .psel          (psel_q),
    .reduced       (reduced)
);

// File: tb/test_ins_position_sel.sv
module test_ins_position_sel;
    localparam int CLK_PERIOD = 10;
    localparam int SET_W = 10;
    localparam int CNT_W = 8;
    localparam int POS_W = 4;

    // Set indices chosen by hand from the R6 mapping (5+5 index bits)
    localparam logic [SET_W-1:0] S_FOLLOW  = 10'd5;
    localparam logic [SET_W-1:0] S_MAP_LO  = 10'd99;
    localparam logic [SET_W-1:0] S_MAP_HI  = 10'd561;
    localparam logic [SET_W-1:0] S_LRU_LO  = 10'd93;
    localparam logic [SET_W-1:0] S_LRU_HI  = 10'd589;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fill_valid = 1'b0;
    logic [SET_W-1:0] fill_set = '0;
    logic             map_reuse_hit = 1'b0;
    logic [CNT_W-1:0] zone_acc_cnt = '0;
    logic [CNT_W-1:0] zone_reuse_cnt = '0;
    logic [2:0]       filter_class = 3'd2;
    logic             miss_valid = 1'b0;
    logic [SET_W-1:0] miss_set = '0;
    logic             fill_bypass;
    logic [POS_W-1:0] fill_pos;
    logic             fill_uses_map;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ins_position_sel i_ins_position_sel (
        .clk            (clk),
        .rst_n          (rst_n),
        .fill_valid     (fill_valid),
        .fill_set       (fill_set),
        .map_reuse_hit  (map_reuse_hit),
        .zone_acc_cnt   (zone_acc_cnt),
        .zone_reuse_cnt (zone_reuse_cnt),
        .filter_class   (filter_class),
        .miss_valid     (miss_valid),
        .miss_set       (miss_set),
        .fill_bypass    (fill_bypass),
        .fill_pos       (fill_pos),
        .fill_uses_map  (fill_uses_map)
    );

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic probe(input logic [SET_W-1:0] s, input logic hit,
                         input int acc, input int reu, input int cls);
        @(negedge clk);
        fill_valid     = 1'b1;
        fill_set       = s;
        map_reuse_hit  = hit;
        zone_acc_cnt   = CNT_W'(acc);
        zone_reuse_cnt = CNT_W'(reu);
        filter_class   = 3'(cls);
        #1;
    endtask

    task automatic misses(input logic [SET_W-1:0] s, input int n);
        fill_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            miss_valid = 1'b1;
            miss_set   = s;
        end
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        fill_valid = 1'b0;
        #1;
        check("R10 idle bypass", int'(fill_bypass), 0);
        check("R10 idle pos", int'(fill_pos), 0);
        check("R10 idle uses_map", int'(fill_uses_map), 0);
        probe(S_FOLLOW, 1'b0, 3, 3, 2);
        check("R6 follower at reset uses map", int'(fill_uses_map), 1);
    endtask

    task automatic t_depth_chain();
        probe(S_FOLLOW, 1'b0, 10, 5, 2);
        check("R3 start depth", int'(fill_pos), 15);
        check("R2 no bypass 10 vs 5", int'(fill_bypass), 0);
        probe(S_FOLLOW, 1'b1, 10, 5, 2);
        check("R3 hit halves", int'(fill_pos), 7);
        probe(S_FOLLOW, 1'b0, 4, 9, 2);
        check("R4 reuse>acc halves", int'(fill_pos), 7);
        probe(S_FOLLOW, 1'b1, 10, 20, 2);
        check("R4 both halves", int'(fill_pos), 3);
        probe(S_FOLLOW, 1'b1, 5, 5, 2);
        check("R4 equal counts no halve", int'(fill_pos), 7);
        probe(S_FOLLOW, 1'b1, 2, 5, 3);
        check("R5 useful third halve", int'(fill_pos), 1);
        probe(S_FOLLOW, 1'b1, 4, 1, 3);
        check("R5 useful after hit", int'(fill_pos), 3);
        probe(S_FOLLOW, 1'b1, 2, 9, 4);
        check("R5 reuse forces 0", int'(fill_pos), 0);
        probe(S_FOLLOW, 1'b1, 2, 9, 1);
        check("R5 useless forces 15", int'(fill_pos), 15);
        probe(S_FOLLOW, 1'b1, 2, 9, 6);
        check("R5 code 6 acts normal", int'(fill_pos), 3);
    endtask

    task automatic t_bypass();
        probe(S_FOLLOW, 1'b0, 3, 3, 0);
        check("R1 class bypass", int'(fill_bypass), 1);
        probe(S_FOLLOW, 1'b0, 17, 1, 2);
        check("R2 17 vs 1 bypass", int'(fill_bypass), 1);
        probe(S_FOLLOW, 1'b0, 16, 1, 2);
        check("R2 16 vs 1 keep", int'(fill_bypass), 0);
        probe(S_FOLLOW, 1'b0, 1, 0, 2);
        check("R2 1 vs 0 bypass", int'(fill_bypass), 1);
        probe(S_FOLLOW, 1'b0, 0, 0, 2);
        check("R2 0 vs 0 keep", int'(fill_bypass), 0);
        probe(S_FOLLOW, 1'b0, 255, 16, 4);
        check("R2 255 vs 16 keep", int'(fill_bypass), 0);
    endtask

    task automatic t_roles_and_plain();
        probe(S_LRU_HI, 1'b0, 40, 0, 0);
        check("R6 lru-dedicated uses plain", int'(fill_uses_map), 0);
        check("R7 plain no bypass", int'(fill_bypass), 0);
        check("R7 plain pos 0", int'(fill_pos), 0);
        probe(S_MAP_HI, 1'b0, 3, 3, 2);
        check("R6 map-dedicated uses map", int'(fill_uses_map), 1);
        probe(S_MAP_LO, 1'b1, 3, 3, 2);
        check("R6 map-dedicated lo", int'(fill_uses_map), 1);
        probe(S_FOLLOW, 1'b0, 3, 3, 2);
        fill_valid = 1'b0;
        #1;
        check("R10 valid low quiet", int'(fill_uses_map), 0);
    endtask

    task automatic t_duel_walk();
        misses(S_MAP_LO, 1);            // 511
        probe(S_FOLLOW, 1'b0, 3, 3, 2);
        check("R8 follower flips to plain at 511", int'(fill_uses_map), 0);
        misses(S_LRU_LO, 1);            // 512
        probe(S_FOLLOW, 1'b0, 3, 3, 2);
        check("R11 follower back to map at 512", int'(fill_uses_map), 1);
        misses(S_FOLLOW, 20);           // unchanged 512
        probe(S_FOLLOW, 1'b0, 3, 3, 2);
        check("R8 follower misses ignored", int'(fill_uses_map), 1);
        misses(S_LRU_LO, 447);          // 959
        probe(S_LRU_HI, 1'b0, 3, 3, 2);
        check("R9 959 still full", int'(fill_uses_map), 0);
        misses(S_LRU_LO, 1);            // 960
        probe(S_LRU_HI, 1'b0, 3, 3, 2);
        check("R9 960 demotes high set", int'(fill_uses_map), 1);
        misses(S_MAP_HI, 5);            // demoted: ignored
        probe(S_LRU_HI, 1'b0, 3, 3, 2);
        check("R9 demoted misses ignored", int'(fill_uses_map), 1);
        misses(S_LRU_LO, 80);           // 1023 saturated
        misses(S_MAP_LO, 63);           // 960
        probe(S_LRU_HI, 1'b0, 3, 3, 2);
        check("R8 top saturation 960", int'(fill_uses_map), 1);
        misses(S_MAP_LO, 1);            // 959
        probe(S_LRU_HI, 1'b0, 3, 3, 2);
        check("R9 959 restores role", int'(fill_uses_map), 0);
        misses(S_MAP_LO, 447);          // 512
        misses(S_MAP_LO, 448);          // 64
        probe(S_MAP_HI, 1'b0, 3, 3, 2);
        check("R9 64 full", int'(fill_uses_map), 1);
        misses(S_MAP_LO, 1);            // 63
        probe(S_MAP_HI, 1'b0, 3, 3, 2);
        check("R9 63 demotes low band", int'(fill_uses_map), 0);
        misses(S_MAP_LO, 100);          // 0 saturated
        misses(S_LRU_LO, 64);           // 64
        probe(S_MAP_HI, 1'b0, 3, 3, 2);
        check("R8 bottom saturation 64", int'(fill_uses_map), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_depth_chain();
        t_bypass();
        t_roles_and_plain();
        t_duel_walk();
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule